// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences exception entry and exception return for a small 32-bit RISC core that has branch delay slots. The core presents a request: the PC of the faulting instruction, an exception code, a flag that tells whether the instruction sat in a delay slot, and the live status word. The block then works out the saved exception PC, the saved status copy, the error address and the new status word. It also produces a redirect to the handler, which is found from a base chosen by a high-vector status bit plus the code shifted left by eight. A trap code does not enter a handler. It raises a debug-halt pulse that carries the PC. A return request writes the saved status copy back and redirects to the saved PC.

The saved exception PC, saved status and error address registers live inside the block and are visible as outputs. The core owns the status register. It applies `sr_we`/`sr_wdata` and clears its pending delay-slot flag on `clr_dslot`.

Exception and return requests share one valid/ready handshake. A request is taken on a rising edge where its valid and `req_ready` are both high. `req_ready` drops for the cycle after every accepted request, so at most one request is in flight. A requester that sees `req_ready` low must hold its valid and its data. An exception request takes priority over a return request presented in the same cycle. The held return is taken at the next opportunity.

Top module: `exc_entry_ctrl`

## Requirements
- R1: `req_ready` is high when idle and low for exactly the cycle after an accepted request. All results are one-cycle pulses that appear in the cycle after acceptance, and no result is produced for a cycle in which nothing was accepted.
- R2: On entry, `redirect_pc` equals (code << 8) plus a base. The base is 0xF0000000 when bit 14 of `cur_sr` is set and 0x00000000 otherwise.
- R3: On entry, `epcr0` is set as follows. For system call (code 0x0C) it is PC+4, or PC when in a delay slot. For illegal instruction (0x07), range (0x0B) and floating-point (0x0D) it is PC, or PC-4 when in a delay slot.
- R4: On entry, `esr0` takes the whole `cur_sr` value.
- R5: On entry, `sr_we` pulses and `sr_wdata` is `cur_sr` with these changes: bit 0 (supervisor) set, bit 1 (tick enable) and bit 2 (interrupt enable) cleared, and bit 13 set to the delay-slot flag.
- R6: `eear0` is loaded with the PC only on an illegal-instruction entry (0x07). Other entries leave it unchanged.
- R7: `clr_dslot` pulses on every entry and on every return, and at no other time.
- R8: A trap request (code 0x0E) pulses `halt_valid` with `halt_pc` equal to the request PC. It produces no redirect, no status write and no change to `epcr0`, `esr0` or `eear0`.
- R9: A code outside {0x07, 0x0B, 0x0C, 0x0D, 0x0E} pulses `exc_err` and changes no state and no other output.
- R10: A return pulses `sr_we` with `sr_wdata` equal to `esr0` and redirects to `epcr0`. If an exception request is valid in the same cycle, the exception is accepted and the return waits.
- R11: After reset, `epcr0`, `esr0` and `eear0` are zero, every pulse output is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Exception request valid |
| exc_code | input | 5 | Exception code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_dslot | input | 1 | Faulting instruction was in a delay slot |
| cur_sr | input | 32 | Live status register |
| rfe_valid | input | 1 | Return-from-exception request valid |
| req_ready | output | 1 | Shared ready for both requests |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| sr_we | output | 1 | Status register write pulse |
| sr_wdata | output | 32 | New status register value |
| clr_dslot | output | 1 | Clear pending delay-slot flag |
| halt_valid | output | 1 | Debug halt pulse for a trap |
| halt_pc | output | 32 | PC reported with the halt |
| exc_err | output | 1 | Unsupported exception code pulse |
| epcr0 | output | 32 | Saved exception PC |
| esr0 | output | 32 | Saved status word |
| eear0 | output | 32 | Error effective address |

## Verification
Every result, both the pulses and the saved registers, is registered once. It is therefore due in the cycle right after the edge that accepts the request. The bench drives requests on the falling edge, lets one rising edge accept them, and reads all outputs on the next falling edge. At that same point it withdraws the request and expects `req_ready` low. One more falling edge later it checks that `req_ready` has returned high and that no pulse remains. Held-request and priority cases count the pulses edge by edge, so a result that arrives a cycle early or late does not match.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int XLEN = 32;

  // exception codes
  localparam logic [4:0] CODE_ILLEGAL = 5'h07;
  localparam logic [4:0] CODE_RANGE   = 5'h0B;
  localparam logic [4:0] CODE_SYSCALL = 5'h0C;
  localparam logic [4:0] CODE_FPE     = 5'h0D;
  localparam logic [4:0] CODE_TRAP    = 5'h0E;

  // status word bit positions
  localparam int SRB_SUPER = 0;
  localparam int SRB_TICK  = 1;
  localparam int SRB_IRQ   = 2;
  localparam int SRB_DSX   = 13;
  localparam int SRB_HIVEC = 14;

  typedef enum logic [1:0] {
    CLS_RESUME_NEXT,
    CLS_REEXEC,
    CLS_TRAP,
    CLS_BAD
  } exc_class_e;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_ctrl_pkg::*;
(
  input  logic [4:0] code,
  output exc_class_e cls,
  output logic       is_illegal
);
  always_comb begin
    is_illegal = 1'b0;
    unique case (code)
      CODE_SYSCALL: cls = CLS_RESUME_NEXT;
      CODE_ILLEGAL: begin cls = CLS_REEXEC; is_illegal = 1'b1; end
      CODE_RANGE,
      CODE_FPE:     cls = CLS_REEXEC;
      CODE_TRAP:    cls = CLS_TRAP;
      default:      cls = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_ctrl_pkg::*;
#(
  parameter int W         = 32,
  parameter int CODE_W    = 5,
  parameter int VEC_SHIFT = 8,
  parameter logic [W-1:0] HI_BASE = 32'hF000_0000
) (
  input  logic [CODE_W-1:0] code,
  input  logic [W-1:0]      pc,
  input  logic              dslot,
  input  logic [W-1:0]      cur_sr,
  input  exc_class_e        cls,
  output logic [W-1:0]      vec_pc,
  output logic [W-1:0]      epc,
  output logic [W-1:0]      new_sr
);
  localparam int PAD_W = W - CODE_W - VEC_SHIFT;
  localparam logic [W-1:0] INSN_BYTES = W'(4);

  logic [W-1:0] offset;
  logic [W-1:0] base;

  assign offset = {{PAD_W{1'b0}}, code, {VEC_SHIFT{1'b0}}};
  assign base   = cur_sr[SRB_HIVEC] ? HI_BASE : '0;
  assign vec_pc = base + offset;

  always_comb begin
    if (cls == CLS_RESUME_NEXT)
      epc = dslot ? pc : pc + INSN_BYTES;
    else
      epc = dslot ? pc - INSN_BYTES : pc;
  end

  always_comb begin
    new_sr            = cur_sr;
    new_sr[SRB_SUPER] = 1'b1;
    new_sr[SRB_TICK]  = 1'b0;
    new_sr[SRB_IRQ]   = 1'b0;
    new_sr[SRB_DSX]   = dslot;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_ctrl_pkg::*;
#(
  parameter int W      = XLEN,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [W-1:0]      exc_pc,
  input  logic              exc_dslot,
  input  logic [W-1:0]      cur_sr,
  input  logic              rfe_valid,
  output logic              req_ready,
  output logic              redirect_valid,
  output logic [W-1:0]      redirect_pc,
  output logic              sr_we,
  output logic [W-1:0]      sr_wdata,
  output logic              clr_dslot,
  output logic              halt_valid,
  output logic [W-1:0]      halt_pc,
  output logic              exc_err,
  output logic [W-1:0]      epcr0,
  output logic [W-1:0]      esr0,
  output logic [W-1:0]      eear0
);
  exc_class_e   cls;
  logic         is_illegal;
  logic [W-1:0] vec_pc, epc, new_sr;
  logic         busy_q;
  logic         take_exc, take_rfe;

  exc_classify u_cls (
    .code       (exc_code),
    .cls        (cls),
    .is_illegal (is_illegal)
  );

  exc_vector #(.W(W), .CODE_W(CODE_W)) u_vec (
    .code   (exc_code),
    .pc     (exc_pc),
    .dslot  (exc_dslot),
    .cur_sr (cur_sr),
    .cls    (cls),
    .vec_pc (vec_pc),
    .epc    (epc),
    .new_sr (new_sr)
  );

  assign req_ready = ~busy_q;
  assign take_exc  = exc_valid & req_ready;
  assign take_rfe  = rfe_valid & req_ready & ~exc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q         <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      sr_we          <= 1'b0;
      sr_wdata       <= '0;
      clr_dslot      <= 1'b0;
      halt_valid     <= 1'b0;
      halt_pc        <= '0;
      exc_err        <= 1'b0;
      epcr0          <= '0;
      esr0           <= '0;
      eear0          <= '0;
    end else begin
      busy_q         <= take_exc | take_rfe;
      redirect_valid <= 1'b0;
      sr_we          <= 1'b0;
      clr_dslot      <= 1'b0;
      halt_valid     <= 1'b0;
      exc_err        <= 1'b0;
      if (take_exc) begin
        unique case (cls)
          CLS_TRAP: begin
            halt_valid <= 1'b1;
            halt_pc    <= exc_pc;
          end
          CLS_BAD: exc_err <= 1'b1;
          default: begin
            epcr0          <= epc;
            esr0           <= cur_sr;
            if (is_illegal) eear0 <= exc_pc;
            sr_we          <= 1'b1;
            sr_wdata       <= new_sr;
            redirect_valid <= 1'b1;
            redirect_pc    <= vec_pc;
            clr_dslot      <= 1'b1;
          end
        endcase
      end else if (take_rfe) begin
        sr_we          <= 1'b1;
        sr_wdata       <= esr0;
        redirect_valid <= 1'b1;
        redirect_pc    <= epcr0;
        clr_dslot      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [31:0] cur_sr,
  input logic        rfe_valid,
  input logic        req_ready,
  input logic        redirect_valid,
  input logic        sr_we,
  input logic        clr_dslot,
  input logic        halt_valid,
  input logic        exc_err,
  input logic [31:0] epcr0,
  input logic [31:0] esr0,
  input logic [31:0] eear0
);
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc_valid || rfe_valid) && req_ready) |=> !req_ready); // R1

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && req_ready) |=> ($countones({redirect_valid, halt_valid, exc_err}) == 1)); // R1

  AST_ESR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && req_ready) |=> (!sr_we || esr0 == $past(cur_sr))); // R4

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halt_valid |-> (!redirect_valid && !sr_we && !clr_dslot
                    && $stable(epcr0) && $stable(esr0) && $stable(eear0))); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    exc_err |-> (!redirect_valid && !sr_we && !halt_valid && !clr_dslot
                 && $stable(epcr0) && $stable(esr0) && $stable(eear0))); // R9

  AST_CLR_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dslot |-> redirect_valid); // R7
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .exc_valid      (exc_valid),
  .cur_sr         (cur_sr),
  .rfe_valid      (rfe_valid),
  .req_ready      (req_ready),
  .redirect_valid (redirect_valid),
  .sr_we          (sr_we),
  .clr_dslot      (clr_dslot),
  .halt_valid     (halt_valid),
  .exc_err        (exc_err),
  .epcr0          (epcr0),
  .esr0           (esr0),
  .eear0          (eear0)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic        exc_dslot = 1'b0;
  logic [31:0] cur_sr = '0;
  logic        rfe_valid = 1'b0;
  logic        req_ready, redirect_valid, sr_we, clr_dslot, halt_valid, exc_err;
  logic [31:0] redirect_pc, sr_wdata, halt_pc, epcr0, esr0, eear0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_epc = '0, m_esr = '0, m_eear = '0;

  always #10 clk = ~clk;

  exc_entry_ctrl u_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_dslot(exc_dslot), .cur_sr(cur_sr), .rfe_valid(rfe_valid),
    .req_ready(req_ready), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .clr_dslot(clr_dslot), .halt_valid(halt_valid),
    .halt_pc(halt_pc), .exc_err(exc_err), .epcr0(epcr0), .esr0(esr0), .eear0(eear0)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_vec(logic [4:0] c, logic [31:0] sr);
    return (sr[14] ? 32'hF000_0000 : 32'h0) + ({27'd0, c} << 8);
  endfunction

  function automatic logic [31:0] f_epc(logic [4:0] c, logic [31:0] pc, logic ds);
    if (c == 5'h0C) return ds ? pc : pc + 32'd4;
    return ds ? pc - 32'd4 : pc;
  endfunction

  function automatic logic [31:0] f_sr(logic [31:0] sr, logic ds);
    logic [31:0] r = sr;
    r[0] = 1'b1; r[1] = 1'b0; r[2] = 1'b0; r[13] = ds;
    return r;
  endfunction

  function automatic bit f_entry(logic [4:0] c);
    return c == 5'h07 || c == 5'h0B || c == 5'h0C || c == 5'h0D;
  endfunction

  // one-cycle gap: ready must come back and no pulse may linger
  task automatic idle_check();
    @(negedge clk);
    chk("R1 ready back", {31'd0, req_ready}, 32'd1);
    chk("R1 no stray pulse",
        {27'd0, redirect_valid, sr_we, clr_dslot, halt_valid, exc_err}, 32'd0);
  endtask

  task automatic do_exc(logic [4:0] c, logic [31:0] pc, logic ds, logic [31:0] sr);
    exc_valid = 1'b1; exc_code = c; exc_pc = pc; exc_dslot = ds; cur_sr = sr;
    @(negedge clk);
    exc_valid = 1'b0;
    chk("R1 ready low", {31'd0, req_ready}, 32'd0);
    if (c == 5'h0E) begin
      chk("R8 halt", {31'd0, halt_valid}, 32'd1);
      chk("R8 halt_pc", halt_pc, pc);
      chk("R8 quiet", {29'd0, redirect_valid, sr_we, exc_err}, 32'd0);
    end else if (!f_entry(c)) begin
      chk("R9 err", {31'd0, exc_err}, 32'd1);
      chk("R9 quiet", {28'd0, redirect_valid, sr_we, halt_valid, clr_dslot}, 32'd0);
    end else begin
      m_epc = f_epc(c, pc, ds);
      m_esr = sr;
      if (c == 5'h07) m_eear = pc;
      chk("R2 vector", redirect_pc, f_vec(c, sr));
      chk("R2 redirect", {31'd0, redirect_valid}, 32'd1);
      chk("R5 sr", sr_wdata, f_sr(sr, ds));
      chk("R5 sr_we", {31'd0, sr_we}, 32'd1);
      chk("R7 clr_dslot", {31'd0, clr_dslot}, 32'd1);
    end
    chk("R3 epcr0", epcr0, m_epc);
    chk("R4 esr0", esr0, m_esr);
    chk("R6 eear0", eear0, m_eear);
    idle_check();
  endtask

  task automatic do_rfe();
    rfe_valid = 1'b1;
    @(negedge clk);
    rfe_valid = 1'b0;
    chk("R10 redirect", {31'd0, redirect_valid}, 32'd1);
    chk("R10 target", redirect_pc, m_epc);
    chk("R10 sr", sr_wdata, m_esr);
    chk("R10 sr_we", {31'd0, sr_we}, 32'd1);
    chk("R7 clr on return", {31'd0, clr_dslot}, 32'd1);
    idle_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 epcr0", epcr0, 0);
    chk("R11 esr0", esr0, 0);
    chk("R11 eear0", eear0, 0);
    chk("R11 pulses", {27'd0, redirect_valid, sr_we, clr_dslot, halt_valid, exc_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ready", {31'd0, req_ready}, 32'd1);

    // directed corners
    do_exc(5'h0C, 32'h0000_1000, 1'b0, 32'h0000_0006);      // R3 syscall, no slot
    do_exc(5'h0C, 32'h0000_2000, 1'b1, 32'h0000_4006);      // R3 syscall in slot, R2 high base
    do_exc(5'h07, 32'h0000_3004, 1'b1, 32'hFFFF_FFFF);      // R6 illegal, R5 all-ones
    do_exc(5'h0B, 32'h0000_4000, 1'b0, 32'h0000_0000);      // R6 eear0 kept
    do_exc(5'h1F, 32'h0000_5000, 1'b0, 32'h0000_4000);      // R9
    do_exc(5'h0E, 32'hDEAD_BEE0, 1'b1, 32'h0000_0007);      // R8
    do_rfe();                                               // R10

    // R10 priority: both valid, exception first, return after
    exc_valid = 1'b1; rfe_valid = 1'b1;
    exc_code = 5'h0D; exc_pc = 32'h0000_7000; exc_dslot = 1'b0; cur_sr = 32'h0000_0123;
    @(negedge clk);
    exc_valid = 1'b0;
    m_epc = 32'h0000_7000; m_esr = 32'h0000_0123;
    chk("R10 exception wins", redirect_pc, f_vec(5'h0D, 32'h0000_0123));
    @(negedge clk);
    chk("R1 held return waits", {31'd0, redirect_valid}, 32'd0);
    do_rfe();

    // R1 back-pressure: held request accepted every other edge
    begin
      int pulses = 0;
      exc_valid = 1'b1; exc_code = 5'h0B; exc_pc = 32'h100; exc_dslot = 1'b0; cur_sr = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (redirect_valid) pulses++;
      end
      exc_valid = 1'b0;
      chk("R1 held request pulses", pulses, 2);
      m_epc = 32'h100; m_esr = 0;
      idle_check();
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [4:0] c;
      int sel = $urandom_range(0, 9);
      case (sel)
        0, 1: c = 5'h0C;
        2, 3: c = 5'h07;
        4:    c = 5'h0B;
        5:    c = 5'h0D;
        6:    c = 5'h0E;
        7:    c = 5'($urandom_range(0, 6));
        default: c = 5'($urandom);
      endcase
      do_exc(c, {$urandom} & 32'hFFFF_FFFC, 1'($urandom), $urandom);
      if ($urandom_range(0, 3) == 0) do_rfe();
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule